// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control path of a superscalar register-rename stage. Each cycle decode may present a group of up to `RN_WIDTH` instructions. A group carries a count, a per-slot "killed" flag and a per-slot count of destination registers. The controller decides which slots of the group are renamed this cycle and reports them as a grant mask. It also reports how many physical registers those grants consume. The map-table lookups sit outside the block. They take the grant mask and the register count from it.

Three things limit how far the controller goes through a group. The first is the reorder-buffer and issue-queue free counts, each reduced by the entries that may already be in flight. The second is the physical-register free count. The third is any stall asserted by the execute or commit stages. When a group cannot be finished, the controller parks it in a skid buffer of whole groups and remembers which slot it reached. It then holds a stall to decode and later replays the parked groups oldest first, resuming inside the partly consumed one. A squash from commit discards everything parked and holds the stage quiet until commit lets go.

Top module: `rn_stall_ctrl`

## Requirements
- R1: After reset, `state_o` is Idle, and with no group present `stall_dec` is 0 and `grant` is 0. The state codes are Idle=0, Running=1, Blocked=2, Unblocking=3 and Squashing=4.
- R2: Usable ROB credit is `rob_free - RN_WIDTH*DELAY` and usable IQ credit is `iq_free - RN_WIDTH*DELAY`. In Idle or Running with a group present, the grants go to the lowest live slots, and their number is the smaller of the two credits and the live count. Each grant with destination count d adds d to `regs_used`.
- R3: If the smaller credit is zero or negative, a present group gets no grant. The group is parked, `stall_dec` is 1 and the next state is Blocked.
- R4: If the smaller credit is positive but below the number of live slots, only that many slots are granted. The group is parked with its resume index, `stall_dec` is 1 and the next state is Blocked. Otherwise the next state is Running.
- R5: A slot whose bit in `dec_kill` is set is skipped. It gets no grant, uses no credit and does not stop the walk.
- R6: The walk stops at the first live slot whose destination count exceeds the physical registers still unclaimed this cycle. Later slots are not granted, and the stage blocks as in R4. `regs_used` never exceeds `preg_free`.
- R7: In Unblocking the granted slots come from the oldest parked group, starting at the saved resume index, and `grant_from_skid` is 1. When that group finishes it is released and the index returns to 0. `stall_dec` stays 1 while any parked group remains after the cycle. Once the buffer drains the state returns to Running with `stall_dec` 0.
- R8: In Blocked, `stall_dec` is 1, no slot is granted and a present group is parked. The state leaves Blocked only when neither downstream stall is set, both credits are positive and `preg_free` is nonzero. It goes to Unblocking if anything is parked, and to Running otherwise.
- R9: In Idle, Running or Unblocking, `iew_stall` or `cmt_stall` grants nothing, parks a present group, raises `stall_dec` and moves to Blocked.
- R10: `cmt_squash` or `cmt_rob_squashing` in any state empties the skid buffer, zeroes the resume index and moves to Squashing, with no grant and `stall_dec` 0 in that cycle. The first cycle in Squashing with both low behaves as Running.
- R11: In Idle or Running with `dec_cnt` 0 and no downstream stall, nothing is granted, `stall_dec` is 0 and the next state is Idle.
- R12: The skid buffer holds `SKID_DEPTH` whole groups and replays them in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_cnt | input | IDX_W | Number of slots in the incoming group (0 = none) |
| dec_kill | input | RN_WIDTH | Per-slot killed flag |
| dec_dst | input | RN_WIDTH*DST_W | Per-slot destination-register count, slot 0 in the low bits |
| rob_free | input | FREE_W | Free reorder-buffer entries reported by commit |
| iq_free | input | FREE_W | Free issue-queue entries reported by execute |
| preg_free | input | PREG_W | Free physical registers |
| iew_stall | input | 1 | Stall request from execute |
| cmt_stall | input | 1 | Stall request from commit |
| cmt_squash | input | 1 | Squash request from commit |
| cmt_rob_squashing | input | 1 | Commit is still walking back the reorder buffer |
| stall_dec | output | 1 | Stall to decode |
| grant | output | RN_WIDTH | Slots of the source group renamed this cycle |
| grant_from_skid | output | 1 | Granted slots come from the oldest parked group |
| regs_used | output | PREG_W | Physical registers claimed this cycle |
| state_o | output | 3 | Controller state code |

## Verification
The assertions assume that decode stops offering groups soon enough after `stall_dec` rises that the skid buffer never holds more than `SKID_DEPTH` groups. They also assume that a parked group always has live slots left past its resume index. The stimulus fills the buffer to exactly its depth and sends nothing further until it has drained. Between scenarios the stimulus returns the controller to Idle through a squash pulse, so every parked group stays consistent with what decode offered.

// File: rtl/rnsc_pkg.sv
package rnsc_pkg;

    localparam int RN_WIDTH = 4;
    localparam int DST_W    = 2;
    localparam int IDX_W    = $clog2(RN_WIDTH + 1);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLK   = 3'd2,
        ST_UNBLK = 3'd3,
        ST_SQ    = 3'd4
    } rn_state_e;

    typedef struct packed {
        logic [IDX_W-1:0]                cnt;
        logic [RN_WIDTH-1:0]             kill;
        logic [RN_WIDTH-1:0][DST_W-1:0]  dst;
    } rn_group_t;

    function automatic logic [IDX_W-1:0] slot_id(input int k);
        return IDX_W'(k);
    endfunction

endpackage

// File: rtl/rn_credit.sv
module rn_credit
    import rnsc_pkg::*;
#(
    parameter int FREE_W = 8,
    parameter int DELAY  = 1
) (
    input  logic [FREE_W-1:0] rob_free,
    input  logic [FREE_W-1:0] iq_free,
    output logic              cr_ok,
    output logic [IDX_W-1:0]  lim
);
    localparam int CW = FREE_W + 2;
    localparam logic signed [CW-1:0] RESERVE = CW'(RN_WIDTH * DELAY);
    localparam logic signed [CW-1:0] CAP     = CW'(RN_WIDTH);

    logic signed [CW-1:0] rob_c, iq_c, mn;

    assign rob_c = $signed({2'b00, rob_free}) - RESERVE;
    assign iq_c  = $signed({2'b00, iq_free})  - RESERVE;
    assign mn    = (rob_c < iq_c) ? rob_c : iq_c;
    assign cr_ok = (mn > CW'(0));

    always_comb begin
        if (!cr_ok)
            lim = '0;
        else if (mn >= CAP)
            lim = IDX_W'(RN_WIDTH);
        else
            lim = mn[IDX_W-1:0];
    end

endmodule

// File: rtl/rn_slot_walk.sv
module rn_slot_walk
    import rnsc_pkg::*;
#(
    parameter int PREG_W = 8
) (
    input  rn_group_t           grp,
    input  logic [IDX_W-1:0]    start_idx,
    input  logic [IDX_W-1:0]    lim,
    input  logic [PREG_W-1:0]   preg_free,
    output logic [RN_WIDTH-1:0] take,
    output logic                halted,
    output logic [IDX_W-1:0]    end_idx,
    output logic [PREG_W-1:0]   regs_used
);
    logic [IDX_W-1:0]  cr_c [RN_WIDTH+1];
    logic [PREG_W-1:0] pr_c [RN_WIDTH+1];
    logic              hl_c [RN_WIDTH+1];
    logic [IDX_W-1:0]  at_c [RN_WIDTH+1];

    assign cr_c[0] = lim;
    assign pr_c[0] = preg_free;
    assign hl_c[0] = 1'b0;
    assign at_c[0] = grp.cnt;

    for (genvar k = 0; k < RN_WIDTH; k++) begin : g_slot
        logic              in_rng, live, short_k;
        logic [PREG_W-1:0] need;

        assign need    = {{(PREG_W-DST_W){1'b0}}, grp.dst[k]};
        assign in_rng  = (slot_id(k) >= start_idx) && (slot_id(k) < grp.cnt);
        assign live    = in_rng && !grp.kill[k] && !hl_c[k];
        assign short_k = live && ((cr_c[k] == '0) || (pr_c[k] < need));
        assign take[k] = live && !short_k;

        assign hl_c[k+1] = hl_c[k] | short_k;
        assign at_c[k+1] = short_k ? slot_id(k) : at_c[k];
        assign cr_c[k+1] = take[k] ? cr_c[k] - 1'b1 : cr_c[k];
        assign pr_c[k+1] = take[k] ? pr_c[k] - need : pr_c[k];
    end

    assign halted    = hl_c[RN_WIDTH];
    assign end_idx   = at_c[RN_WIDTH];
    assign regs_used = preg_free - pr_c[RN_WIDTH];

endmodule

// File: rtl/rn_skid.sv
module rn_skid
    import rnsc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  logic      pop,
    input  logic      flush,
    input  rn_group_t din,
    output rn_group_t head,
    output logic      empty,
    output logic      full,
    output logic      one_left
);
    rn_group_t        mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [OCC_W-1:0] occ_q;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (occ_q == '0);
    assign full     = (occ_q == OCC_W'(DEPTH));
    assign one_left = (occ_q == OCC_W'(1));
    assign do_pop   = pop && !empty;
    assign do_push  = push && (!full || do_pop);
    assign head     = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            occ_q <= '0;
        end else begin
            if (do_push) wr_q <= bump(wr_q);
            if (do_pop)  rd_q <= bump(rd_q);
            case ({do_push, do_pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // R12
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !flush) |-> pop);

    // R7
    pop_has_data_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> !empty);

endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
    import rnsc_pkg::*;
#(
    parameter int FREE_W     = 8,
    parameter int PREG_W     = 8,
    parameter int DELAY      = 1,
    parameter int SKID_DEPTH = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDX_W-1:0]          dec_cnt,
    input  logic [RN_WIDTH-1:0]       dec_kill,
    input  logic [RN_WIDTH*DST_W-1:0] dec_dst,
    input  logic [FREE_W-1:0]         rob_free,
    input  logic [FREE_W-1:0]         iq_free,
    input  logic [PREG_W-1:0]         preg_free,
    input  logic                      iew_stall,
    input  logic                      cmt_stall,
    input  logic                      cmt_squash,
    input  logic                      cmt_rob_squashing,
    output logic                      stall_dec,
    output logic [RN_WIDTH-1:0]       grant,
    output logic                      grant_from_skid,
    output logic [PREG_W-1:0]         regs_used,
    output logic [2:0]                state_o
);
    rn_state_e        state_q, state_n, act;
    logic [IDX_W-1:0] idx_q, idx_n;

    rn_group_t        in_grp, src_grp, head_grp;
    logic             has_in, squash_any, down_stall, use_skid;
    logic             cr_ok;
    logic [IDX_W-1:0] lim, start_idx, end_idx;
    logic [RN_WIDTH-1:0] walk_take;
    logic             walk_halt;
    logic [PREG_W-1:0] walk_regs;
    logic             push, pop, flush, do_walk;
    logic             sk_empty, sk_full, sk_one;

    assign in_grp.cnt  = dec_cnt;
    assign in_grp.kill = dec_kill;
    assign in_grp.dst  = dec_dst;

    assign has_in     = (dec_cnt != '0);
    assign squash_any = cmt_squash | cmt_rob_squashing;
    assign down_stall = iew_stall | cmt_stall;
    assign use_skid   = (state_q == ST_UNBLK);
    assign src_grp    = use_skid ? head_grp : in_grp;
    assign start_idx  = use_skid ? idx_q : '0;

    rn_credit #(.FREE_W(FREE_W), .DELAY(DELAY)) u_credit (
        .rob_free (rob_free),
        .iq_free  (iq_free),
        .cr_ok    (cr_ok),
        .lim      (lim)
    );

    rn_slot_walk #(.PREG_W(PREG_W)) u_walk (
        .grp       (src_grp),
        .start_idx (start_idx),
        .lim       (lim),
        .preg_free (preg_free),
        .take      (walk_take),
        .halted    (walk_halt),
        .end_idx   (end_idx),
        .regs_used (walk_regs)
    );

    rn_skid #(.DEPTH(SKID_DEPTH)) u_skid (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .din      (in_grp),
        .head     (head_grp),
        .empty    (sk_empty),
        .full     (sk_full),
        .one_left (sk_one)
    );

    always_comb begin
        state_n   = state_q;
        idx_n     = idx_q;
        push      = 1'b0;
        pop       = 1'b0;
        flush     = 1'b0;
        stall_dec = 1'b0;
        do_walk   = 1'b0;
        act       = (state_q == ST_SQ) ? ST_RUN : state_q;

        if (squash_any) begin
            flush   = 1'b1;
            idx_n   = '0;
            state_n = ST_SQ;
        end else begin
            case (act)
                ST_IDLE, ST_RUN: begin
                    if (down_stall) begin
                        push      = has_in;
                        stall_dec = 1'b1;
                        state_n   = ST_BLK;
                    end else if (!has_in) begin
                        state_n = ST_IDLE;
                    end else if (!cr_ok) begin
                        push      = 1'b1;
                        stall_dec = 1'b1;
                        state_n   = ST_BLK;
                    end else begin
                        do_walk = 1'b1;
                        if (walk_halt) begin
                            push      = 1'b1;
                            idx_n     = end_idx;
                            stall_dec = 1'b1;
                            state_n   = ST_BLK;
                        end else begin
                            idx_n   = '0;
                            state_n = ST_RUN;
                        end
                    end
                end
                ST_UNBLK: begin
                    push = has_in;
                    if (down_stall || !cr_ok) begin
                        stall_dec = 1'b1;
                        state_n   = ST_BLK;
                    end else begin
                        do_walk = 1'b1;
                        if (walk_halt) begin
                            idx_n     = end_idx;
                            stall_dec = 1'b1;
                            state_n   = ST_BLK;
                        end else begin
                            pop   = 1'b1;
                            idx_n = '0;
                            if (sk_one && !has_in) begin
                                state_n = ST_RUN;
                            end else begin
                                stall_dec = 1'b1;
                                state_n   = ST_UNBLK;
                            end
                        end
                    end
                end
                ST_BLK: begin
                    push      = has_in;
                    stall_dec = 1'b1;
                    if (!down_stall && cr_ok && (preg_free != '0))
                        state_n = (sk_empty && !has_in) ? ST_RUN : ST_UNBLK;
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    assign grant           = do_walk ? walk_take : '0;
    assign regs_used       = do_walk ? walk_regs : '0;
    assign grant_from_skid = do_walk && use_skid;
    assign state_o         = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    // R3
    no_credit_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !cr_ok |-> (grant == '0));

    // R4
    grant_within_credit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant) <= int'(lim));

    // R6
    regs_fit_chk: assert property (@(posedge clk) disable iff (rst)
        regs_used <= preg_free);

    // R8
    blocked_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BLK && !squash_any) |-> (stall_dec && grant == '0));

    // R10
    squash_enter_chk: assert property (@(posedge clk) disable iff (rst)
        squash_any |=> (state_q == ST_SQ));

    // R10
    squash_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        squash_any |-> (!stall_dec && grant == '0));

    // R7
    idx_zero_when_running_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN || state_q == ST_IDLE) |-> (idx_q == '0));

endmodule

// File: tb/tb_rn_stall_ctrl.sv
`timescale 1ns/1ps
module tb_rn_stall_ctrl;
    import rnsc_pkg::*;

    localparam int S_IDLE = 0, S_RUN = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [IDX_W-1:0]          dec_cnt = '0;
    logic [RN_WIDTH-1:0]       dec_kill = '0;
    logic [RN_WIDTH*DST_W-1:0] dec_dst = '0;
    logic [7:0] rob_free = '0, iq_free = '0, preg_free = '0;
    logic iew_stall = 1'b0, cmt_stall = 1'b0, cmt_squash = 1'b0, cmt_rob_squashing = 1'b0;
    logic stall_dec, grant_from_skid;
    logic [RN_WIDTH-1:0] grant;
    logic [7:0] regs_used;
    logic [2:0] state_o;

    int ncheck = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rn_stall_ctrl dut (
        .clk(clk), .rst(rst), .dec_cnt(dec_cnt), .dec_kill(dec_kill), .dec_dst(dec_dst),
        .rob_free(rob_free), .iq_free(iq_free), .preg_free(preg_free),
        .iew_stall(iew_stall), .cmt_stall(cmt_stall), .cmt_squash(cmt_squash),
        .cmt_rob_squashing(cmt_rob_squashing), .stall_dec(stall_dec), .grant(grant),
        .grant_from_skid(grant_from_skid), .regs_used(regs_used), .state_o(state_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        ncheck++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input int c, input int k, input int d, input int r, input int q, input int p);
        dec_cnt   = IDX_W'(c);
        dec_kill  = RN_WIDTH'(k);
        dec_dst   = (RN_WIDTH*DST_W)'(d);
        rob_free  = 8'(r);
        iq_free   = 8'(q);
        preg_free = 8'(p);
    endtask

    task automatic look(input string req, input int g, input int s, input int fs);
        #1;
        chk(req, "grant", int'(grant), g);
        chk(req, "stall_dec", int'(stall_dec), s);
        chk(req, "grant_from_skid", int'(grant_from_skid), fs);
    endtask

    task automatic step_state(input string req, input int st);
        tick();
        chk(req, "state", int'(state_o), st);
    endtask

    task automatic go_idle();
        drive(0, 0, 0, 0, 0, 0);
        cmt_squash = 1'b1;
        tick();
        cmt_squash = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", ncheck, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "state", int'(state_o), S_IDLE);
        chk("R1", "stall_dec", int'(stall_dec), 0);
        chk("R1", "grant", int'(grant), 0);
        rst = 1'b0;
        tick();
        chk("R1", "state after release", int'(state_o), S_IDLE);

        // R2 R3 R4 R11: credit sweep, no kills, one destination per slot
        for (int r = 0; r < 10; r++) begin
            for (int q = 0; q < 10; q++) begin
                for (int c = 0; c <= RN_WIDTH; c++) begin
                    int m, g, eg, es, est;
                    string tag;
                    go_idle();
                    drive(c, 0, 'h55, r, q, 20);
                    m = ((r < q) ? r : q) - RN_WIDTH;
                    if (c == 0) begin
                        tag = "R11"; g = 0; es = 0; est = S_IDLE;
                    end else if (m <= 0) begin
                        tag = "R3"; g = 0; es = 1; est = S_BLK;
                    end else begin
                        g = (m < c) ? m : c;
                        es = (g < c) ? 1 : 0;
                        est = es ? S_BLK : S_RUN;
                        tag = es ? "R4" : "R2";
                    end
                    eg = (1 << g) - 1;
                    look(tag, eg, es, 0);
                    chk(tag, "regs_used", int'(regs_used), g);
                    step_state(tag, est);
                end
            end
        end

        // R5: every kill pattern against each positive credit
        for (int k = 0; k < 16; k++) begin
            for (int m = 1; m <= RN_WIDTH; m++) begin
                int taken, eg, blk;
                go_idle();
                drive(4, k, 'h55, RN_WIDTH + m, 20, 20);
                taken = 0; eg = 0; blk = 0;
                for (int s = 0; s < 4; s++) begin
                    if (((k >> s) & 1) == 0 && blk == 0) begin
                        if (taken < m) begin
                            eg |= (1 << s);
                            taken++;
                        end else begin
                            blk = 1;
                        end
                    end
                end
                look("R5", eg, blk, 0);
                chk("R5", "regs_used", int'(regs_used), taken);
                step_state("R5", blk ? S_BLK : S_RUN);
            end
        end

        // R6: register-limited walk, destination counts 2,0,3,1 in slots 0..3
        for (int p = 0; p < 8; p++) begin
            int d[4];
            int rem, eg, blk, used;
            d[0] = 2; d[1] = 0; d[2] = 3; d[3] = 1;
            go_idle();
            drive(4, 0, (1 << 6) | (3 << 4) | (0 << 2) | 2, 20, 20, p);
            rem = p; eg = 0; blk = 0; used = 0;
            for (int s = 0; s < 4; s++) begin
                if (blk == 0) begin
                    if (rem >= d[s]) begin
                        eg |= (1 << s);
                        rem -= d[s];
                        used += d[s];
                    end else begin
                        blk = 1;
                    end
                end
            end
            look("R6", eg, blk, 0);
            chk("R6", "regs_used", int'(regs_used), used);
            step_state("R6", blk ? S_BLK : S_RUN);
        end

        // R7: partial group resumes at the saved slot
        go_idle();
        drive(4, 0, 'h55, 6, 20, 20);
        look("R4", 'b0011, 1, 0);
        step_state("R4", S_BLK);
        drive(0, 0, 'h55, 20, 20, 20);
        look("R8", 0, 1, 0);
        step_state("R8", S_UNB);
        look("R7", 'b1100, 0, 1);
        chk("R7", "regs_used", int'(regs_used), 2);
        step_state("R7", S_RUN);

        // R8 R12: fill the skid buffer to depth while registers are exhausted
        go_idle();
        drive(4, 0, 'h55, 5, 20, 20);
        look("R4", 'b0001, 1, 0);
        step_state("R4", S_BLK);
        for (int c = 1; c <= 3; c++) begin
            drive(c, 0, 'h55, 20, 20, 0);
            look("R8", 0, 1, 0);
            step_state("R8", S_BLK);
        end
        drive(0, 0, 'h55, 20, 20, 20);
        step_state("R8", S_UNB);
        look("R12", 'b1110, 1, 1);
        step_state("R12", S_UNB);
        look("R12", 'b0001, 1, 1);
        step_state("R12", S_UNB);
        look("R12", 'b0011, 1, 1);
        step_state("R12", S_UNB);
        look("R12", 'b0111, 0, 1);
        step_state("R7", S_RUN);

        // R9: downstream stall in Running, then again during Unblocking
        go_idle();
        drive(2, 0, 'h55, 20, 20, 20);
        iew_stall = 1'b1;
        look("R9", 0, 1, 0);
        step_state("R9", S_BLK);
        iew_stall = 1'b0;
        drive(0, 0, 'h55, 20, 20, 20);
        step_state("R8", S_UNB);
        cmt_stall = 1'b1;
        look("R9", 0, 1, 0);
        step_state("R9", S_BLK);
        look("R8", 0, 1, 0);
        step_state("R8", S_BLK);
        cmt_stall = 1'b0;
        step_state("R8", S_UNB);
        look("R7", 'b0011, 0, 1);
        step_state("R7", S_RUN);

        // R10: squash while blocked with a parked group
        go_idle();
        drive(4, 0, 'h55, 5, 20, 20);
        step_state("R4", S_BLK);
        drive(0, 0, 'h55, 20, 20, 20);
        cmt_rob_squashing = 1'b1;
        look("R10", 0, 0, 0);
        step_state("R10", S_SQ);
        drive(2, 0, 'h55, 20, 20, 20);
        look("R10", 0, 0, 0);
        step_state("R10", S_SQ);
        cmt_rob_squashing = 1'b0;
        drive(0, 0, 'h55, 20, 20, 20);
        step_state("R10", S_IDLE);
        cmt_stall = 1'b1;
        step_state("R9", S_BLK);
        cmt_stall = 1'b0;
        step_state("R10", S_RUN);
        // R10: first cycle after Squashing renames a present group
        cmt_squash = 1'b1;
        step_state("R10", S_SQ);
        cmt_squash = 1'b0;
        drive(3, 0, 'h55, 20, 20, 20);
        look("R10", 'b0111, 0, 0);
        step_state("R10", S_RUN);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", ncheck, nbad);
        $finish;
    end

endmodule